// File: doc/BRIEF.md
# Codec Power-State Sequencer

This block decides whether a voice codec is running or powered down, and it controls when the codec's outputs may drive. Two things send the codec into power-down. The first is an active-low power-down pin. The second is both frame syncs staying silent for several frame periods while the master clock keeps running. Either one gates the clocks and places the transmit-data and analog outputs in high impedance. The block stands in for bias and analog switching with plain control outputs.

Leaving power-down needs two things: the pin must be high, and a rising edge must appear on the transmit frame sync. The block then keeps the transmit-data driver off for a guard interval, counted in transmit frame starts, and enables it exactly at a frame start. When the transmit sync keeps running but the receive sync stops (half-channel operation), the block mutes the receive path. It releases the mute when receive sync edges return.

Everything runs on the master clock. The pin is asynchronous and passes through a synchronizer. The frame syncs are sampled directly on the master clock.

Top module: `codec_pwr_seq`

## Requirements
- R1: A low level on `pdn_pin_n` passes through a `SYNC_STAGES` (2) flop synchronizer. `pdn_state_n` goes to 0 on the third clock edge after the pin falls. At the same point `dt_oe` also goes to 0.
- R2: Both frame syncs may go without a rising edge for `IDLE_FRAMES` (4) periods of `FRAME_CYCLES` clocks, counted from their last common rising edge. The block then powers down on the edge after the last of those periods completes.
- R3: The block leaves power-down on the clock edge that samples a rising edge of `fs_tx`, provided the synchronized pin is already high. Rising edges of `fs_rx` alone never power the block up.
- R4: After power-up, `dt_oe` stays 0 until `GUARD_FRAMES` (2) more rising edges of `fs_tx` have occurred. It rises on the edge that samples the last of them, which is the start of a frame.
- R5: The pin takes priority over sync activity. While the synchronized pin is low, `fs_tx` edges do not power the block up. This includes an edge that arrives before a newly raised pin has passed through the synchronizer.
- R6: Out of reset, `pdn_state_n`, `clk_run`, `ana_oe`, `dt_oe` and `rx_mute` are all 0.
- R7: While powered, `rx_mute` rises on the edge that completes one full frame period without an `fs_rx` rising edge. It falls on the edge that samples the next `fs_rx` rising edge.
- R8: If only one of the two syncs goes idle, the block stays powered and `dt_oe` stays 1.
- R9: `clk_run` and `ana_oe` are 1 exactly when `pdn_state_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_pin_n | input | 1 | Asynchronous power-down pin, 0 requests power-down |
| fs_tx | input | 1 | Transmit frame sync, sampled on clk |
| fs_rx | input | 1 | Receive frame sync, sampled on clk |
| pdn_state_n | output | 1 | 0 while powered down, 1 while running |
| clk_run | output | 1 | Internal clock gate enable |
| ana_oe | output | 1 | Analog output drive enable |
| dt_oe | output | 1 | Transmit data drive enable |
| rx_mute | output | 1 | Ties the receive path to analog ground |

## Verification
A sync rising edge acts on the same clock edge that samples it, so wake-up, guard completion and mute release all become visible one edge after the pulse is applied. A pin change needs three edges: two synchronizer flops plus the state register. Sync-idle power-down lands one edge after the counted idle window ends. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the following edges. It checks each result on the exact edge it is due, and it also checks the edge just before, where the old value must still hold.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
   typedef enum logic [1:0] {
      PS_DOWN  = 2'd0,
      PS_GUARD = 2'd1,
      PS_LIVE  = 2'd2
   } pwr_state_t;

   localparam int NUM_SYNC = 2;
   localparam int CH_TX    = 0;
   localparam int CH_RX    = 1;
endpackage

// File: rtl/pwr_sync_chain.sv
module pwr_sync_chain #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwr_sync_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[s] <= RST_VAL;
            else        sr[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr[s] <= RST_VAL;
            else        sr[s] <= sr[s-1];
         end
      end
   end

   assign q_sync = sr[STAGES-1];
endmodule

// File: rtl/pwr_frame_watch.sv
module pwr_frame_watch #(
   parameter int FRAME_CYCLES = 32,
   parameter int IDLE_FRAMES  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs,
   output logic rise,
   output logic missing,
   output logic idle
);
   localparam int CYC_W  = (FRAME_CYCLES > 1) ? $clog2(FRAME_CYCLES) : 1;
   localparam int MISS_W = $clog2(IDLE_FRAMES + 1);
   localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(FRAME_CYCLES - 1);
   localparam logic [MISS_W-1:0] MISS_FULL = MISS_W'(IDLE_FRAMES);

   if (FRAME_CYCLES < 4) begin : g_bad_frame
      $error("pwr_frame_watch: FRAME_CYCLES must be at least 4");
   end
   if (IDLE_FRAMES < 1) begin : g_bad_idle
      $error("pwr_frame_watch: IDLE_FRAMES must be at least 1");
   end

   logic              fs_q;
   logic [CYC_W-1:0]  cyc;
   logic [MISS_W-1:0] miss;

   assign rise = fs & ~fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q <= 1'b0;
         cyc  <= '0;
         miss <= '0;
      end else begin
         fs_q <= fs;
         if (rise) begin
            cyc  <= '0;
            miss <= '0;
         end else if (cyc == CYC_LAST) begin
            cyc <= '0;
            if (miss != MISS_FULL) miss <= miss + 1'b1;
         end else begin
            cyc <= cyc + 1'b1;
         end
      end
   end

   assign missing = (miss != '0);
   assign idle    = (miss == MISS_FULL);

   AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      miss <= MISS_FULL) else $error("miss count overflow"); // R2
   AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !missing) else $error("rise did not clear miss count"); // R7
endmodule

// File: rtl/pwr_guard_cnt.sv
module pwr_guard_cnt #(
   parameter int GUARD_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic done
);
   localparam int CNT_W = $clog2(GUARD_FRAMES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GUARD_FRAMES - 1);

   if (GUARD_FRAMES < 1) begin : g_bad_guard
      $error("pwr_guard_cnt: GUARD_FRAMES must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (clear)          cnt <= '0;
      else if (tick && !done)  cnt <= cnt + 1'b1;
   end

   assign done = tick && (cnt == CNT_LAST) && !clear;

   AST_GUARD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_LAST) else $error("guard count out of range"); // R4
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
   import codec_pwr_pkg::*;
#(
   parameter int FRAME_CYCLES = 32,
   parameter int IDLE_FRAMES  = 4,
   parameter int GUARD_FRAMES = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pdn_pin_n,
   input  logic fs_tx,
   input  logic fs_rx,
   output logic pdn_state_n,
   output logic clk_run,
   output logic ana_oe,
   output logic dt_oe,
   output logic rx_mute
);
   logic                pin_s;
   logic [NUM_SYNC-1:0] fs_in, fs_rise, fs_miss, fs_idle;
   logic                guard_done;
   pwr_state_t          state, state_nx;

   pwr_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_pin_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pdn_pin_n), .q_sync(pin_s)
   );

   assign fs_in[CH_TX] = fs_tx;
   assign fs_in[CH_RX] = fs_rx;

   for (genvar c = 0; c < NUM_SYNC; c++) begin : g_watch
      pwr_frame_watch #(.FRAME_CYCLES(FRAME_CYCLES), .IDLE_FRAMES(IDLE_FRAMES)) i_watch (
         .clk(clk), .rst_n(rst_n), .fs(fs_in[c]),
         .rise(fs_rise[c]), .missing(fs_miss[c]), .idle(fs_idle[c])
      );
   end

   pwr_guard_cnt #(.GUARD_FRAMES(GUARD_FRAMES)) i_guard (
      .clk(clk), .rst_n(rst_n), .clear(state != PS_GUARD),
      .tick(fs_rise[CH_TX]), .done(guard_done)
   );

   always_comb begin
      state_nx = state;
      if (!pin_s) begin
         state_nx = PS_DOWN;
      end else begin
         unique case (state)
            PS_DOWN:  if (fs_rise[CH_TX]) state_nx = PS_GUARD;
            PS_GUARD: begin
               if (&fs_idle)        state_nx = PS_DOWN;
               else if (guard_done) state_nx = PS_LIVE;
            end
            PS_LIVE:  if (&fs_idle) state_nx = PS_DOWN;
            default:  state_nx = PS_DOWN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_DOWN;
      else        state <= state_nx;
   end

   assign pdn_state_n = (state != PS_DOWN);
   assign clk_run     = pdn_state_n;
   assign ana_oe      = pdn_state_n;
   assign dt_oe       = (state == PS_LIVE);
   assign rx_mute     = pdn_state_n && fs_miss[CH_RX];

   AST_PIN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_s |=> (state == PS_DOWN)) else $error("pin low did not power down"); // R1
   AST_IDLE_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      ((&fs_idle) && state != PS_DOWN) |=> (state == PS_DOWN)) else $error("idle syncs kept power"); // R2
   AST_WAKE_TX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pdn_state_n) |-> $past(fs_rise[CH_TX] && pin_s)) else $error("wake without tx edge"); // R3
   AST_DT_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dt_oe) |-> $past(fs_rise[CH_TX])) else $error("dt enable off frame start"); // R4
   AST_MUTE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      fs_rise[CH_RX] |=> !rx_mute) else $error("mute held after rx edge"); // R7
endmodule

// File: tb/test_codec_pwr_seq.sv
module test_codec_pwr_seq;
   localparam int F = 16;
   localparam int IDLE = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pdn_pin_n = 1'b1;
   logic fs_tx = 1'b0;
   logic fs_rx = 1'b0;
   logic pdn_state_n, clk_run, ana_oe, dt_oe, rx_mute;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   codec_pwr_seq #(.FRAME_CYCLES(F), .IDLE_FRAMES(IDLE), .GUARD_FRAMES(2), .SYNC_STAGES(2))
   i_codec_pwr_seq (
      .clk(clk), .rst_n(rst_n), .pdn_pin_n(pdn_pin_n), .fs_tx(fs_tx), .fs_rx(fs_rx),
      .pdn_state_n(pdn_state_n), .clk_run(clk_run), .ana_oe(ana_oe),
      .dt_oe(dt_oe), .rx_mute(rx_mute)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic pulse(input logic tx, input logic rx);
      fs_tx = tx;
      fs_rx = rx;
      tick(1);
      fs_tx = 1'b0;
      fs_rx = 1'b0;
   endtask

   task automatic frame(input logic tx, input logic rx);
      pulse(tx, rx);
      tick(F - 1);
   endtask

   task automatic t_reset();
      tick(3);
      chk("R6", "pdn_state_n", pdn_state_n, 1'b0);
      chk("R6", "dt_oe", dt_oe, 1'b0);
      chk("R6", "rx_mute", rx_mute, 1'b0);
      chk("R9", "clk_run", clk_run, 1'b0);
      chk("R9", "ana_oe", ana_oe, 1'b0);
      rst_n = 1'b1;
      tick(3);
   endtask

   task automatic t_wake_guard();
      pulse(1'b1, 1'b1);
      chk("R3", "powered after tx edge", pdn_state_n, 1'b1);
      chk("R9", "ana_oe on", ana_oe, 1'b1);
      chk("R9", "clk_run on", clk_run, 1'b1);
      chk("R4", "dt_oe blank frame 0", dt_oe, 1'b0);
      tick(F - 1);
      pulse(1'b1, 1'b1);
      chk("R4", "dt_oe blank frame 1", dt_oe, 1'b0);
      tick(F - 1);
      chk("R4", "dt_oe just before guard end", dt_oe, 1'b0);
      pulse(1'b1, 1'b1);
      chk("R4", "dt_oe at frame start", dt_oe, 1'b1);
      tick(F - 1);
   endtask

   task automatic t_half_channel();
      tick(0);
      chk("R7", "no mute before miss", rx_mute, 1'b0);
      pulse(1'b1, 1'b0);
      chk("R7", "mute after missed rx frame", rx_mute, 1'b1);
      tick(F - 1);
      for (int k = 0; k < IDLE + 2; k++) frame(1'b1, 1'b0);
      chk("R8", "rx idle alone keeps power", pdn_state_n, 1'b1);
      chk("R8", "rx idle alone keeps dt_oe", dt_oe, 1'b1);
      chk("R7", "mute held while rx idle", rx_mute, 1'b1);
      pulse(1'b1, 1'b1);
      chk("R7", "mute released on rx edge", rx_mute, 1'b0);
      tick(F - 1);
      for (int k = 0; k < IDLE + 2; k++) frame(1'b0, 1'b1);
      chk("R8", "tx idle alone keeps power", pdn_state_n, 1'b1);
      chk("R8", "tx idle alone keeps dt_oe", dt_oe, 1'b1);
      frame(1'b1, 1'b1);
   endtask

   task automatic t_sync_idle();
      pulse(1'b1, 1'b1);
      tick(IDLE * F);
      chk("R2", "still powered at idle limit", pdn_state_n, 1'b1);
      tick(1);
      chk("R2", "powered down after idle", pdn_state_n, 1'b0);
      chk("R2", "dt_oe off after idle", dt_oe, 1'b0);
      chk("R9", "ana_oe off after idle", ana_oe, 1'b0);
   endtask

   task automatic t_rx_no_wake();
      for (int k = 0; k < 3; k++) frame(1'b0, 1'b1);
      chk("R3", "rx edges do not wake", pdn_state_n, 1'b0);
      pulse(1'b1, 1'b1);
      chk("R3", "tx edge wakes from idle", pdn_state_n, 1'b1);
      chk("R4", "dt_oe blank after idle wake", dt_oe, 1'b0);
      tick(F - 1);
      frame(1'b1, 1'b1);
      pulse(1'b1, 1'b1);
      chk("R4", "dt_oe after second guard", dt_oe, 1'b1);
      tick(3);
   endtask

   task automatic t_pin();
      pdn_pin_n = 1'b0;
      tick(2);
      chk("R1", "power held 2 edges after pin", pdn_state_n, 1'b1);
      tick(1);
      chk("R1", "down 3 edges after pin", pdn_state_n, 1'b0);
      chk("R1", "dt_oe off with pin", dt_oe, 1'b0);
      chk("R9", "clk_run off with pin", clk_run, 1'b0);
      tick(F - 6);
      for (int k = 0; k < 3; k++) frame(1'b1, 1'b1);
      chk("R5", "tx edges ignored while pin low", pdn_state_n, 1'b0);
      pdn_pin_n = 1'b1;
      pulse(1'b1, 1'b1);
      chk("R5", "edge before sync of pin ignored", pdn_state_n, 1'b0);
      tick(F - 1);
      pulse(1'b1, 1'b1);
      chk("R3", "wake after pin release", pdn_state_n, 1'b1);
      chk("R4", "dt_oe blank after pin wake", dt_oe, 1'b0);
      tick(F - 1);
      frame(1'b1, 1'b1);
      pulse(1'b1, 1'b1);
      chk("R4", "dt_oe after pin-wake guard", dt_oe, 1'b1);
   endtask

   initial begin
      t_reset();
      t_wake_guard();
      t_half_channel();
      t_sync_idle();
      t_rx_no_wake();
      t_pin();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule